// File: doc/BRIEF.md
# Four-Channel Edge-Select Capture Timer

This block contains a free-running up-counter and four capture channels. Each channel watches its own external pin. The pin is passed through a synchronizer, and on the edge that channel is set to respond to, the channel stores the current counter value. Every channel then raises a sticky status flag. That flag drives an interrupt request and a DMA request, each behind its own enable. When the counter rolls over from all-ones to zero it sets an overflow flag, which drives its own interrupt request. The prescaler is outside the block: a single-cycle count-enable input stands in for the prescaled tick.

Channel D has a second trigger source. A control bit hands channel D over to a compare-match strobe that comes from another timer on the same clock. While that bit is set, each strobe captures the counter and the pin for channel D is ignored. This holds even when the edge setting for channel D is disabled.

Software reaches the block through a plain single-cycle register port. A write takes effect at the clock edge on which `wr_en` is high. A read is combinational from `rd_addr`. There is no handshake and no back-pressure: every access completes in the cycle it is presented.

Top module: `ect_capture_timer`

## Requirements
- R1: After reset the counter, all capture values, all flags, all enables and the control word are zero, and `cap_irq`, `cap_dma` and `ovf_irq` are low.
- R2: The counter rises by exactly one at each clock edge where `cnt_en` is high, and keeps its value at every other edge.
- R3: When the counter steps from all-ones it becomes zero and sets the overflow flag (bit 4 of the flag register). `ovf_irq` equals that flag ANDed with bit 4 of the interrupt-enable register.
- R4: Control register (address 0) bits [2i+1:2i] select the edge for channel i (A=0 ... D=3). The codes are 00 off, 01 rising, 10 falling and 11 both. A channel captures only on the selected edge, and with 00 its capture value never changes.
- R5: A pin change is first seen at one clock edge. The capture and its flag are written two edges later, and the stored value is the counter value in the cycle just before that write.
- R6: With control bit 8 set, a high `cmp_match` at a clock edge stores the counter into channel D and sets flag 3, whatever the channel D edge code. Pin D is ignored in this mode. With bit 8 clear, `cmp_match` has no effect.
- R7: Flag bits (address 1: bits 3..0 for channels, bit 4 for overflow) stay set until a 1 is written to that bit position. Writing 0 leaves them unchanged, and a set event at the same edge as a clear leaves the flag set.
- R8: `cap_irq[i]` is flag i ANDed with bit i of the interrupt-enable register (address 2). `cap_dma[i]` is flag i ANDed with bit i of the DMA-enable register (address 3). The two enables are independent.
- R9: Reads return control at 0, flags at 1, interrupt enables at 2, DMA enables at 3, captures A..D at 4..7 and the counter at 8, zero-extended. Other addresses read zero, and writes to addresses 4 to 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Single-cycle count tick |
| cap_pin | input | 4 | Asynchronous capture pins, bit i is channel i |
| cmp_match | input | 1 | Compare-match strobe from another timer, same clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data, combinational |
| cap_irq | output | 4 | Per-channel capture interrupt requests |
| cap_dma | output | 4 | Per-channel capture DMA requests |
| ovf_irq | output | 1 | Counter overflow interrupt request |

## Verification
Each edge code is driven with both a rising and a falling pin transition, so the test shows whether a channel responds to the right edge and ignores the other. The counter is moved between events so that a stale or wrong capture value shows up. One capture is made with the counter running, which fixes the exact cycle of the stored value and exposes a wrong number of synchronizer stages. Channel D is driven both by the strobe and by its pin in both trigger modes, including a strobe that lands on the same edge as a flag clear, to confirm which source is allowed through and that a set event wins over a clear.

// File: rtl/ect_pkg.sv
package ect_pkg;
  localparam int NUM_CH = 4;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_FLAGS = 4'd1;
  localparam logic [ADDR_W-1:0] A_IRQEN = 4'd2;
  localparam logic [ADDR_W-1:0] A_DMAEN = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAP0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CNT   = 4'd8;

  // control word: edge codes in the low 2*NUM_CH bits, then the strobe select
  localparam int CTRL_W = 2 * NUM_CH + 1;
  localparam int CMSEL_BIT = 2 * NUM_CH;
  // flag word: one bit per channel, overflow on top
  localparam int FLAG_W = NUM_CH + 1;
endpackage

// File: rtl/ect_sync_edge.sv
module ect_sync_edge
  import ect_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  edge_mode_e mode,
  output logic       hit
);
  // STAGES flops of synchronizer plus one history flop for edge detection
  logic [STAGES:0] pipe_q;
  logic cur, prev, rise, fall;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-1:0], pin};
  end

  assign cur  = pipe_q[STAGES-1];
  assign prev = pipe_q[STAGES];
  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ect_counter.sv
module ect_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = en && (cnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n)  cnt <= '0;
    else if (en) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ect_capture_reg.sv
module ect_capture_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (trig) q <= din;
  end
endmodule

// File: rtl/ect_regs.sv
module ect_regs
  import ect_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [REG_W-1:0]    wr_data,
  input  logic [NUM_CH-1:0]   cap_evt,
  input  logic                ovf_evt,
  output logic [2*NUM_CH-1:0] modes,
  output logic                cmsel,
  output logic [FLAG_W-1:0]   flags,
  output logic [FLAG_W-1:0]   irq_en,
  output logic [NUM_CH-1:0]   dma_en
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [FLAG_W-1:0] flag_set, flag_clr;
  logic unused_wr_hi;

  assign unused_wr_hi = ^wr_data[REG_W-1:CTRL_W];

  assign flag_set = {ovf_evt, cap_evt};
  assign flag_clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      flags  <= '0;
      irq_en <= '0;
      dma_en <= '0;
    end else begin
      // a set event at the same edge as a clear keeps the flag
      flags <= (flags & ~flag_clr) | flag_set;
      if (wr_en) begin
        unique case (wr_addr)
          A_CTRL:  ctrl_q <= wr_data[CTRL_W-1:0];
          A_IRQEN: irq_en <= wr_data[FLAG_W-1:0];
          A_DMAEN: dma_en <= wr_data[NUM_CH-1:0];
          default: ;
        endcase
      end
    end
  end

  assign modes = ctrl_q[2*NUM_CH-1:0];
  assign cmsel = ctrl_q[CMSEL_BIT];
endmodule

// File: rtl/ect_capture_timer.sv
module ect_capture_timer
  import ect_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic [3:0]        cap_pin,
  input  logic              cmp_match,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [3:0]        rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [3:0]        cap_irq,
  output logic [3:0]        cap_dma,
  output logic              ovf_irq
);
  localparam int LAST = NUM_CH - 1;

  logic [CNT_W-1:0]    cnt_q;
  logic                cnt_wrap;
  logic [2*NUM_CH-1:0] modes_q;
  logic                cmsel_q;
  logic [FLAG_W-1:0]   flags_q;
  logic [FLAG_W-1:0]   irq_en_q;
  logic [NUM_CH-1:0]   dma_en_q;
  logic [NUM_CH-1:0]   pin_hit;
  logic [NUM_CH-1:0]   trig;
  logic [CNT_W-1:0]    cap_q [NUM_CH];

  ect_counter #(.W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (cnt_en),
    .cnt  (cnt_q),
    .wrap (cnt_wrap)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    ect_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (cap_pin[i]),
      .mode (edge_mode_e'(modes_q[2*i +: 2])),
      .hit  (pin_hit[i])
    );

    if (i == LAST) begin : g_strobe
      // the last channel can be handed to the compare-match strobe
      assign trig[i] = cmsel_q ? cmp_match : pin_hit[i];
    end else begin : g_pin
      assign trig[i] = pin_hit[i];
    end

    ect_capture_reg #(.W(CNT_W)) u_cap (
      .clk  (clk),
      .rst_n(rst_n),
      .trig (trig[i]),
      .din  (cnt_q),
      .q    (cap_q[i])
    );
  end

  ect_regs #(.REG_W(REG_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .cap_evt(trig),
    .ovf_evt(cnt_wrap),
    .modes  (modes_q),
    .cmsel  (cmsel_q),
    .flags  (flags_q),
    .irq_en (irq_en_q),
    .dma_en (dma_en_q)
  );

  assign cap_irq = flags_q[NUM_CH-1:0] & irq_en_q[NUM_CH-1:0];
  assign cap_dma = flags_q[NUM_CH-1:0] & dma_en_q;
  assign ovf_irq = flags_q[NUM_CH] & irq_en_q[NUM_CH];

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      A_CTRL:  rd_data[CTRL_W-1:0] = {cmsel_q, modes_q};
      A_FLAGS: rd_data[FLAG_W-1:0] = flags_q;
      A_IRQEN: rd_data[FLAG_W-1:0] = irq_en_q;
      A_DMAEN: rd_data[NUM_CH-1:0] = dma_en_q;
      A_CNT:   rd_data[CNT_W-1:0]  = cnt_q;
      default: begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (rd_addr == A_CAP0 + ADDR_W'(i)) rd_data[CNT_W-1:0] = cap_q[i];
        end
      end
    endcase
  end
endmodule

// File: rtl/ect_checker.sv
module ect_checker
  import ect_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic [CNT_W-1:0]  cnt,
  input logic [FLAG_W-1:0] flags,
  input logic [1:0]        mode_a,
  input logic              cmsel,
  input logic              cmp_match,
  input logic [CNT_W-1:0]  cap_a,
  input logic [CNT_W-1:0]  cap_d,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_d0
);
  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt));

  // R3
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt == '1) |=> (flags[NUM_CH] && cnt == '0));

  // R6
  strobe_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmsel && cmp_match) |=> (cap_d == $past(cnt) && flags[NUM_CH-1]));

  // R4
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_a == 2'b00) |=> $stable(cap_a));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !(wr_en && wr_addr == A_FLAGS && wr_d0)) |=> flags[0]);
endmodule

bind ect_capture_timer ect_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_en   (cnt_en),
  .cnt      (cnt_q),
  .flags    (flags_q),
  .mode_a   (modes_q[1:0]),
  .cmsel    (cmsel_q),
  .cmp_match(cmp_match),
  .cap_a    (cap_q[0]),
  .cap_d    (cap_q[ect_pkg::NUM_CH-1]),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_d0    (wr_data[0])
);

// File: tb/tb_ect_capture_timer.sv
module tb_ect_capture_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cnt_en = 0;
  logic [3:0]  cap_pin = '0;
  logic        cmp_match = 0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  cap_irq, cap_dma;
  logic        ovf_irq;

  int errors = 0;
  int checks = 0;
  int ec = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ect_capture_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_pin(cap_pin),
    .cmp_match(cmp_match), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_irq(cap_irq), .cap_dma(cap_dma), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(input int n);
    @(negedge clk);
    cnt_en = 1;
    repeat (n) @(negedge clk);
    cnt_en = 0;
    ec += n;
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    cap_pin[i] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk);
    cmp_match = 1;
    @(negedge clk);
    cmp_match = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk("R1 counter", 4'd8, 0);
    rd_chk("R1 flags", 4'd1, 0);
    rd_chk("R1 capA", 4'd4, 0);
    rd_chk("R1 ctrl", 4'd0, 0);
    chk("R1 irq/dma/ovf", {23'd0, ovf_irq, cap_dma, cap_irq}, 0);
  endtask

  task automatic t_count();
    run(10);
    rd_chk("R2 count", 4'd8, ec);
    repeat (5) @(negedge clk);
    rd_chk("R2 hold", 4'd8, ec);
  endtask

  task automatic t_map();
    wr(4'd8, 32'h55);
    rd_chk("R9 counter write ignored", 4'd8, ec);
    wr(4'd4, 32'hAA);
    rd_chk("R9 capture write ignored", 4'd4, 0);
    rd_chk("R9 unmapped 9", 4'd9, 0);
    rd_chk("R9 unmapped 15", 4'd15, 0);
  endtask

  task automatic t_edges();
    // A rising, B falling, C both
    wr(4'd0, 32'h39);
    rd_chk("R9 ctrl readback", 4'd0, 32'h39);
    set_pin(0, 1);
    rd_chk("R4 A rise capture", 4'd4, 10);
    rd_chk("R4 A flag", 4'd1, 32'h1);
    wr(4'd1, 32'h1);
    rd_chk("R7 clear A", 4'd1, 0);
    run(3);
    set_pin(0, 0);
    rd_chk("R4 A ignores fall", 4'd4, 10);
    rd_chk("R4 A no flag on fall", 4'd1, 0);
    set_pin(1, 1);
    rd_chk("R4 B ignores rise", 4'd5, 0);
    set_pin(1, 0);
    rd_chk("R4 B fall capture", 4'd5, ec);
    rd_chk("R4 B flag", 4'd1, 32'h2);
    set_pin(2, 1);
    rd_chk("R4 C rise capture", 4'd6, ec);
    run(2);
    set_pin(2, 0);
    rd_chk("R4 C fall capture", 4'd6, ec);
    rd_chk("R4 B/C flags", 4'd1, 32'h6);
    // A switched off
    wr(4'd0, 32'h38);
    run(1);
    set_pin(0, 1);
    set_pin(0, 0);
    rd_chk("R4 A off keeps value", 4'd4, 10);
    rd_chk("R4 A off no flag", 4'd1, 32'h6);
    wr(4'd1, 32'h1F);
    rd_chk("R7 clear all", 4'd1, 0);
  endtask

  task automatic t_timing();
    logic [31:0] c;
    wr(4'd0, 32'h39);
    @(negedge clk);
    rd_addr = 4'd8;
    #1;
    c = rd_data;
    chk("R5 counter before", c, ec);
    cap_pin[0] = 1;
    cnt_en = 1;
    repeat (3) @(negedge clk);
    cnt_en = 0;
    ec += 3;
    rd_chk("R5 capture cycle", 4'd4, c + 2);
    rd_chk("R5 flag", 4'd1, 32'h1);
  endtask

  task automatic t_requests();
    wr(4'd2, 32'h1);
    #1;
    chk("R8 irq enabled", {28'd0, cap_irq}, 32'h1);
    chk("R8 dma still off", {28'd0, cap_dma}, 0);
    wr(4'd3, 32'h1);
    #1;
    chk("R8 dma enabled", {28'd0, cap_dma}, 32'h1);
    wr(4'd2, 32'h0);
    #1;
    chk("R8 irq off dma on", {24'd0, cap_irq, cap_dma}, 32'h01);
    wr(4'd1, 32'h0);
    rd_chk("R7 write 0 keeps flag", 4'd1, 32'h1);
    wr(4'd1, 32'h1);
    rd_chk("R7 write 1 clears", 4'd1, 0);
    chk("R8 dma drops", {28'd0, cap_dma}, 0);
  endtask

  task automatic t_strobe();
    wr(4'd0, 32'h100);
    strobe();
    rd_chk("R6 strobe capture mode off", 4'd7, ec);
    rd_chk("R6 flag D", 4'd1, 32'h8);
    wr(4'd0, 32'h1C0);
    run(2);
    set_pin(3, 1);
    set_pin(3, 0);
    rd_chk("R6 pin D ignored", 4'd7, ec - 2);
    wr(4'd1, 32'h8);
    rd_chk("R7 clear D", 4'd1, 0);
    @(negedge clk);
    cmp_match = 1;
    wr_en = 1; wr_addr = 4'd1; wr_data = 32'h8;
    @(negedge clk);
    cmp_match = 0;
    wr_en = 0;
    rd_chk("R7 set wins over clear", 4'd1, 32'h8);
    rd_chk("R6 second strobe", 4'd7, ec);
    wr(4'd0, 32'h0);
    wr(4'd1, 32'h1F);
    run(1);
    strobe();
    rd_chk("R6 strobe ignored when deselected", 4'd7, ec - 1);
    rd_chk("R6 no flag when deselected", 4'd1, 0);
  endtask

  task automatic t_overflow();
    wr(4'd2, 32'h10);
    run(255 - ec);
    rd_chk("R3 at all-ones", 4'd8, 32'hFF);
    chk("R3 no ovf yet", {31'd0, ovf_irq}, 0);
    run(1);
    rd_chk("R3 wrapped", 4'd8, 0);
    rd_chk("R3 ovf flag", 4'd1, 32'h10);
    chk("R3 ovf irq", {31'd0, ovf_irq}, 1);
    wr(4'd1, 32'h10);
    #1;
    chk("R3 ovf irq cleared", {31'd0, ovf_irq}, 0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_map();
    t_edges();
    t_timing();
    t_requests();
    t_strobe();
    t_overflow();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule